// File: doc/BRIEF.md
# Prioritized Fifteen-Level Interrupt Controller

This block gathers interrupt requests from peripheral sources on levels 1 through 15 and holds each one in a sticky pending register until it is serviced. Software can also raise any level directly through a force register. The pending and forced bits are ORed together and gated by a mask register. The block then presents the highest-numbered surviving level to the processor as a 4-bit code. A code of zero means that no interrupt is being requested.

When the processor takes an interrupt, it returns the level it took on the acknowledge port, and the block retires that level's source bit. In the normal case this is the pending bit. With the test-mode override bit of the test control input set, a forced level is retired from the force register instead. A small register port lets software read pending, mask and force, write mask and force, and clear pending bits with a write-one-to-clear register. Level 15 cannot be masked, and level 0 is never used.

Top module: `irq_level_ctrl`

## Requirements
- R1: After reset, pending and force read 0x0000, mask reads 0x3FFF (levels 1 to 13 masked, 14 and 15 open) and `irq_level` is 0.
- R2: A high `src_req[k]` for k in 1..15 during a clock edge sets pending bit k, which stays set afterwards with the request low. `src_req[0]` has no effect.
- R3: `irq_level` is the index of the highest set bit of (pending OR force) AND NOT mask over bits 15..1, or 0 if none is set. It reflects the state registered at the most recent clock edge.
- R4: A mask write stores `wr_data & 0x7FFE`, so bit 15 of mask always reads 0 and level 15 can never be masked.
- R5: A force write stores `wr_data & 0xFFFE`, so force bit 0 always reads 0.
- R6: An acknowledge (`ack_valid` high, `ack_level` = L, L nonzero) clears pending bit L whenever the override condition of R7 does not hold. An acknowledge of level 0 changes nothing.
- R7: If `test_ctrl[19]` is high and force bit L is set during an acknowledge of level L, force bit L is cleared and pending bit L is left as it was.
- R8: A write to the clear register clears each pending bit whose `wr_data` bit is 1 and leaves the pending bits written as 0 unchanged.
- R9: If a request and an acknowledge or clear hit the same pending bit in one cycle, the request wins and the bit stays set.
- R10: The register selects are 0 for pending (read-only, and writes are ignored), 1 for mask, 2 for clear (reads 0x0000) and 3 for force. `rd_data` is combinational from `rd_sel`. A force write in the same cycle as an acknowledge override takes the written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_req | input | 16 | Request per level; bit 0 is unused |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register targeted by the write |
| wr_data | input | 16 | Write data |
| rd_sel | input | 2 | Register shown on rd_data |
| rd_data | output | 16 | Read data of the selected register |
| ack_valid | input | 1 | Processor acknowledge strobe |
| ack_level | input | 4 | Level being acknowledged |
| test_ctrl | input | 32 | Test control word; bit 19 enables the force-acknowledge override |
| irq_level | output | 4 | Highest active level, 0 when idle |

## Verification
The assertions assume that every control input is a known value on each clock edge after reset, and that `ack_level` stays within 0..15. They also assume that a force write and an override acknowledge to the same bit in one cycle resolve in favour of the write.

The stimulus keeps within these assumptions. It drives every input from one task, one time unit after a rising edge, and returns all strobes to idle between operations. It only acknowledges levels from 0 to 15, and it includes exactly one deliberate same-cycle collision of a request with an acknowledge.

// File: rtl/irqc_pkg.sv
// Package irqc_pkg
// Shared register-select encoding for the interrupt level controller.
// Assumes a 2-bit select field on both the write and the read port.
package irqc_pkg;
    typedef enum logic [1:0] {
        SEL_PEND  = 2'd0,
        SEL_MASK  = 2'd1,
        SEL_CLEAR = 2'd2,
        SEL_FORCE = 2'd3
    } irqc_sel_e;
endpackage

// File: rtl/irqc_regs.sv
// Module irqc_regs
// Holds the pending, force and mask state of the controller and applies
// requests, acknowledges and register writes to them.
// Assumes: bit 0 of every vector is unused; a request outranks a clear or an
// acknowledge on the same pending bit; a force write outranks the acknowledge
// override on the same force bit.
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int          NUM_LEVELS = 15,
    parameter int          VEC_W      = NUM_LEVELS + 1,
    parameter int          LVL_W      = $clog2(VEC_W),
    parameter logic [VEC_W-1:0] MASK_RST = VEC_W'(16'h3FFF)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VEC_W-1:0] src_req,
    input  logic             wr_en,
    input  irqc_sel_e        wr_sel,
    input  logic [VEC_W-1:0] wr_data,
    input  logic             ack_valid,
    input  logic [LVL_W-1:0] ack_level,
    input  logic             test_mode,
    output logic [VEC_W-1:0] pend_q,
    output logic [VEC_W-1:0] frc_q,
    output logic [VEC_W-1:0] mask_q
);
    // Mask bits that software may write: 1 .. NUM_LEVELS-1
    localparam logic [VEC_W-1:0] MASK_WR =
        ((VEC_W'(1) << NUM_LEVELS) - VEC_W'(1)) & ~VEC_W'(1);
    // Mask reset with the top level forced open
    localparam logic [VEC_W-1:0] MASK_INIT = MASK_RST & ~(VEC_W'(1) << NUM_LEVELS);

    logic clr_wr;
    logic frc_wr;
    logic msk_wr;

    // Decode the write strobe per register
    always_comb begin
        clr_wr = wr_en && (wr_sel == SEL_CLEAR);
        frc_wr = wr_en && (wr_sel == SEL_FORCE);
        msk_wr = wr_en && (wr_sel == SEL_MASK);
    end

    // Bit 0 of pending and force is never used
    assign pend_q[0] = 1'b0;
    assign frc_q[0]  = 1'b0;

    for (genvar i = 1; i <= NUM_LEVELS; i++) begin : g_lvl
        logic hit;
        logic take_frc;

        // Work out whether this level is acknowledged and which bit it retires
        always_comb begin
            hit      = ack_valid && (ack_level == LVL_W'(i));
            take_frc = hit && test_mode && frc_q[i];
        end

        // Pending bit: request wins over clear and acknowledge
        always_ff @(posedge clk) begin
            if (!rst_n)
                pend_q[i] <= 1'b0;
            else if (src_req[i])
                pend_q[i] <= 1'b1;
            else if ((clr_wr && wr_data[i]) || (hit && !take_frc))
                pend_q[i] <= 1'b0;
        end

        // Force bit: software write wins over the acknowledge override
        always_ff @(posedge clk) begin
            if (!rst_n)
                frc_q[i] <= 1'b0;
            else if (frc_wr)
                frc_q[i] <= wr_data[i];
            else if (take_frc)
                frc_q[i] <= 1'b0;
        end
    end

    // Mask register with the non-writable bits kept clear on write
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= MASK_INIT;
        else if (msk_wr)
            mask_q <= wr_data & MASK_WR;
    end
endmodule

// File: rtl/irqc_prio.sv
// Module irqc_prio
// Combines pending and force, removes masked levels and encodes the
// highest remaining level. Output 0 means nothing active.
// Assumes bit 0 of the inputs carries no request.
module irqc_prio #(
    parameter int NUM_LEVELS = 15,
    parameter int VEC_W      = NUM_LEVELS + 1,
    parameter int LVL_W      = $clog2(VEC_W)
) (
    input  logic [VEC_W-1:0] pend,
    input  logic [VEC_W-1:0] frc,
    input  logic [VEC_W-1:0] mask,
    output logic [LVL_W-1:0] level
);
    logic [VEC_W-1:0] active;

    // Form the unmasked active set, bit 0 excluded
    always_comb begin
        active    = (pend | frc) & ~mask;
        active[0] = 1'b0;
    end

    // Scan upward so the highest active level is the one that remains
    always_comb begin
        level = '0;
        for (int i = 1; i <= NUM_LEVELS; i++) begin
            if (active[i])
                level = LVL_W'(i);
        end
    end
endmodule

// File: rtl/irq_level_ctrl.sv
// Module irq_level_ctrl
// Top of the prioritized interrupt level controller: register state,
// priority encoding and the combinational read-back multiplexer.
// Assumes all inputs are synchronous to clk; reset is synchronous active-low.
module irq_level_ctrl
    import irqc_pkg::*;
#(
    parameter int NUM_LEVELS = 15,
    parameter int TEST_W     = 32,
    parameter int TEST_BIT   = 19,
    parameter int VEC_W      = NUM_LEVELS + 1,
    parameter int LVL_W      = $clog2(VEC_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VEC_W-1:0] src_req,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [VEC_W-1:0] wr_data,
    input  logic [1:0]       rd_sel,
    output logic [VEC_W-1:0] rd_data,
    input  logic             ack_valid,
    input  logic [LVL_W-1:0] ack_level,
    input  logic [TEST_W-1:0] test_ctrl,
    output logic [LVL_W-1:0] irq_level
);
    logic [VEC_W-1:0] pend_q;
    logic [VEC_W-1:0] frc_q;
    logic [VEC_W-1:0] mask_q;
    logic             test_mode;

    // Pick the override bit out of the test control word
    assign test_mode = test_ctrl[TEST_BIT];

    irqc_regs #(
        .NUM_LEVELS (NUM_LEVELS),
        .VEC_W      (VEC_W),
        .LVL_W      (LVL_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_req   (src_req),
        .wr_en     (wr_en),
        .wr_sel    (irqc_sel_e'(wr_sel)),
        .wr_data   (wr_data),
        .ack_valid (ack_valid),
        .ack_level (ack_level),
        .test_mode (test_mode),
        .pend_q    (pend_q),
        .frc_q     (frc_q),
        .mask_q    (mask_q)
    );

    irqc_prio #(
        .NUM_LEVELS (NUM_LEVELS),
        .VEC_W      (VEC_W),
        .LVL_W      (LVL_W)
    ) u_prio (
        .pend  (pend_q),
        .frc   (frc_q),
        .mask  (mask_q),
        .level (irq_level)
    );

    // Read-back multiplexer; the clear register reads as zero
    always_comb begin
        unique case (irqc_sel_e'(rd_sel))
            SEL_PEND:  rd_data = pend_q;
            SEL_MASK:  rd_data = mask_q;
            SEL_FORCE: rd_data = frc_q;
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/irqc_checker.sv
// Module irqc_checker
// Temporal checks on the controller state, bound into irq_level_ctrl.
// Assumes inputs are known at every clock edge after reset.
module irqc_checker #(
    parameter int NUM_LEVELS = 15,
    parameter int TEST_BIT   = 19,
    parameter int TEST_W     = 32,
    parameter int VEC_W      = NUM_LEVELS + 1,
    parameter int LVL_W      = $clog2(VEC_W)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [VEC_W-1:0] src_req,
    input logic             wr_en,
    input logic [1:0]       wr_sel,
    input logic [VEC_W-1:0] wr_data,
    input logic             ack_valid,
    input logic [LVL_W-1:0] ack_level,
    input logic [TEST_W-1:0] test_ctrl,
    input logic [LVL_W-1:0] irq_level,
    input logic [VEC_W-1:0] pend_q,
    input logic [VEC_W-1:0] frc_q,
    input logic [VEC_W-1:0] mask_q
);
    logic [VEC_W-1:0] act;
    logic [VEC_W-1:0] req_use;

    // Reference active set and usable requests for the properties
    always_comb begin
        act     = (pend_q | frc_q) & ~mask_q & ~VEC_W'(1);
        req_use = src_req & ~VEC_W'(1);
    end

    // R2 / R9: every usable request is visible in pending next cycle
    p_req_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_use != '0) |=> ((pend_q & $past(req_use)) == $past(req_use)));

    // R3: the presented level is active and nothing above it is
    p_level_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level != '0) |-> (act[irq_level] && ((act >> irq_level) == VEC_W'(1))));

    // R3: idle code only when the active set is empty
    p_level_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level == '0) |-> (act == '0));

    // R4: a mask write lands with level 15 and bit 0 dropped
    p_mask_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd1) |=> (mask_q == ($past(wr_data) & VEC_W'(16'h7FFE))));

    // R5: a force write lands with bit 0 dropped
    p_force_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd3) |=> (frc_q == ($past(wr_data) & ~VEC_W'(1))));

    // R7: override acknowledge retires the force bit and leaves pending alone
    p_ack_force_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ack_level != '0 && test_ctrl[TEST_BIT] && frc_q[ack_level]
         && !(wr_en && wr_sel == 2'd3))
        |=> (!frc_q[$past(ack_level)]
             && (pend_q[$past(ack_level)] == $past(pend_q[ack_level] | src_req[ack_level]))));
endmodule

bind irq_level_ctrl irqc_checker #(
    .NUM_LEVELS (NUM_LEVELS),
    .TEST_BIT   (TEST_BIT),
    .TEST_W     (TEST_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_req   (src_req),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .ack_valid (ack_valid),
    .ack_level (ack_level),
    .test_ctrl (test_ctrl),
    .irq_level (irq_level),
    .pend_q    (pend_q),
    .frc_q     (frc_q),
    .mask_q    (mask_q)
);

// File: tb/sim_irq_level_ctrl.sv
`timescale 1ns/100ps
// Scoreboard bench: the driver task updates a reference model and queues the
// expected level and read data; the monitor pops and compares at each falling edge.
module sim_irq_level_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] src_req = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  rd_sel = '0;
    logic [15:0] rd_data;
    logic        ack_valid = 1'b0;
    logic [3:0]  ack_level = '0;
    logic [31:0] test_ctrl = '0;
    logic [3:0]  irq_level;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [3:0]  lvl;
        logic [15:0] rd;
        string       tag;
    } exp_t;
    exp_t sb[$];

    logic [15:0] m_pend = 16'h0000;
    logic [15:0] m_frc  = 16'h0000;
    logic [15:0] m_mask = 16'h3FFF;

    always #2.5 clk = ~clk;

    irq_level_ctrl u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_req   (src_req),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .rd_sel    (rd_sel),
        .rd_data   (rd_data),
        .ack_valid (ack_valid),
        .ack_level (ack_level),
        .test_ctrl (test_ctrl),
        .irq_level (irq_level)
    );

    function automatic logic [3:0] ref_level();
        logic [15:0] a;
        logic [3:0]  l;
        a = (m_pend | m_frc) & ~m_mask & 16'hFFFE;
        l = 4'd0;
        for (int i = 1; i < 16; i++) if (a[i]) l = 4'(i);
        return l;
    endfunction

    function automatic logic [15:0] ref_rd(input logic [1:0] s);
        case (s)
            2'd0: return m_pend;
            2'd1: return m_mask;
            2'd3: return m_frc;
            default: return 16'h0000;
        endcase
    endfunction

    // Drive one operation, advance the model, queue the expectation
    task automatic op(input logic [15:0] req, input bit we, input logic [1:0] ws,
                      input logic [15:0] wd, input bit av, input logic [3:0] al,
                      input bit tm, input logic [1:0] rs, input string tag);
        logic [15:0] np, nf, nm;
        exp_t e;
        @(posedge clk);
        #1;
        src_req = req; wr_en = we; wr_sel = ws; wr_data = wd;
        ack_valid = av; ack_level = al; test_ctrl = tm ? 32'h0008_0000 : 32'h0;
        rd_sel = rs;
        np = m_pend; nf = m_frc; nm = m_mask;
        if (we && ws == 2'd2) np = np & ~(wd & 16'hFFFE);
        if (av && al != 4'd0) begin
            if (tm && m_frc[al]) nf[al] = 1'b0;
            else np[al] = 1'b0;
        end
        if (we && ws == 2'd3) nf = wd & 16'hFFFE;
        if (we && ws == 2'd1) nm = wd & 16'h7FFE;
        np = np | (req & 16'hFFFE);
        @(posedge clk);
        m_pend = np; m_frc = nf; m_mask = nm;
        e.lvl = ref_level(); e.rd = ref_rd(rs); e.tag = tag;
        sb.push_back(e);
        #1;
        src_req = '0; wr_en = 1'b0; ack_valid = 1'b0; test_ctrl = '0;
    endtask

    // Monitor: compare queued expectations against the outputs
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (irq_level !== e.lvl) begin
                errors++;
                $display("FAIL %s irq_level actual=%0d expected=%0d", e.tag, irq_level, e.lvl);
            end
            checks++;
            if (rd_data !== e.rd) begin
                errors++;
                $display("FAIL %s rd_data actual=%h expected=%h", e.tag, rd_data, e.rd);
            end
        end
    end

    // Watchdog
    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset values
        op('0, 0, 0, '0, 0, 0, 0, 2'd0, "R1 pend");
        op('0, 0, 0, '0, 0, 0, 0, 2'd1, "R1 mask");
        op('0, 0, 0, '0, 0, 0, 0, 2'd3, "R1 force");
        // R2 masked level still sets pending
        op(16'h0008, 0, 0, '0, 0, 0, 0, 2'd0, "R2 req3 masked");
        // R4 level 15 open after reset
        op(16'h8000, 0, 0, '0, 0, 0, 0, 2'd0, "R4 req15 unmaskable");
        op('0, 1, 2'd1, 16'hFFFF, 0, 0, 0, 2'd1, "R4 mask write all");
        // R6 acknowledge clears pending
        op('0, 0, 0, '0, 1, 4'd15, 0, 2'd0, "R6 ack15");
        op('0, 1, 2'd1, 16'h0000, 0, 0, 0, 2'd1, "R3 unmask all");
        // R3 highest level first
        op(16'h00A0, 0, 0, '0, 0, 0, 0, 2'd0, "R3 req7 req5");
        // R8 clear register
        op('0, 1, 2'd2, 16'h0080, 0, 0, 0, 2'd0, "R8 clear bit7");
        // R5 force writes
        op('0, 1, 2'd3, 16'hFFFF, 0, 0, 0, 2'd3, "R5 force all");
        op('0, 1, 2'd3, 16'h0001, 0, 0, 0, 2'd3, "R5 force bit0");
        op('0, 1, 2'd3, 16'h0200, 0, 0, 0, 2'd3, "R5 force9");
        // R6 without override, the force bit stays
        op('0, 0, 0, '0, 1, 4'd9, 0, 2'd3, "R6 ack9 no test");
        // R7 override retires the force bit
        op('0, 0, 0, '0, 1, 4'd9, 1, 2'd3, "R7 ack9 test force");
        // R7 override with force clear falls back to pending
        op('0, 0, 0, '0, 1, 4'd5, 1, 2'd0, "R7 ack5 test no force");
        // R9 request beats acknowledge
        op(16'h0008, 0, 0, '0, 1, 4'd3, 0, 2'd0, "R9 req ack same");
        // R2 bit 0 ignored
        op(16'h0001, 0, 0, '0, 0, 0, 0, 2'd0, "R2 req bit0");
        // R6 acknowledge of level 0
        op('0, 0, 0, '0, 1, 4'd0, 0, 2'd0, "R6 ack0 ignored");
        // R10 pending is read-only, clear reads zero
        op('0, 1, 2'd0, 16'hFFFF, 0, 0, 0, 2'd0, "R10 pend write ignored");
        op('0, 0, 0, '0, 0, 0, 0, 2'd2, "R10 clear reads zero");
        // R10 force write wins over the override acknowledge
        op('0, 1, 2'd3, 16'h1000, 0, 0, 0, 2'd3, "R5 force12");
        op('0, 1, 2'd3, 16'h1000, 1, 4'd12, 1, 2'd3, "R10 write beats override");
        // R4 mask level 3 hides it
        op('0, 1, 2'd3, 16'h0000, 0, 0, 0, 2'd3, "R5 force none");
        op('0, 1, 2'd1, 16'h0008, 0, 0, 0, 2'd1, "R4 mask3");
        op('0, 0, 0, '0, 0, 0, 0, 2'd0, "R2 pend held under mask");
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule